// File: doc/BRIEF.md
# Video-Mode Packet Event Sequencer

This block walks one display frame from programmed timing and issues, cycle by cycle, the packet events that a display serial link transmitter needs in video mode. Each event is a descriptor made of a 6-bit data type, a 2-bit virtual channel and a 16-bit word count. Serialisation, header protection, checksums and the pixel data are handled elsewhere. Sync markers open every line, and pixel packets cover the active window. Filler packets, or a low-power permission flag, cover the intervals where no pixels flow.

One cycle is one pixel clock. A line is made of four parts in this order: sync width `hsw`, back porch `hbp`, active window `hact`, front porch `hfp`. The frame has one vertical-sync line, then `vbp` back-porch lines, `vact` active lines and `vfp` front-porch lines. A pulse on `start` while idle runs exactly one frame. Timing inputs must stay stable while a frame runs. They must also satisfy `hsw`, `hbp`, `hact`, `max_pix` all at least 1.

Top module: `dsi_vid_sequencer`

## Requirements
- R1: While reset is held and right after it, `ev_valid`, `lp_ok` and `running` are 0.
- R2: A `start` pulse while idle makes the next cycle the first cycle (line 0, position 0) of a frame. The frame lasts (1+vbp+vact+vfp)·(hsw+hbp+hact+hfp) cycles, and then `running` drops. A `start` pulse while running is ignored, including on the final cycle.
- R3: Position 0 of every line carries a marker with word count 0. Line 0 gets vertical sync start (0x01). In `vid_mode` 0, line 1 gets vertical sync end (0x11). Every other line gets horizontal sync start (0x21).
- R4: In `vid_mode` 0 (sync pulses) every line carries horizontal sync end (0x31, word count 0) at position `hsw`. No other mode emits end markers.
- R5: In non-burst modes (`vid_mode` 0, 1, 3), an active line emits pixel packets of type 0x3E at window offsets 0, max_pix, 2·max_pix, and so on. Each has word count 3 × its pixel count, and no packet has more than `max_pix` pixels.
- R6: The last pixel packet of an active line carries the remaining pixels when `hact` is not a multiple of `max_pix`.
- R7: In burst mode (`vid_mode` 2), the pixel packets of an active line are issued on consecutive cycles from window offset 0. The remaining window cycles form a fill interval.
- R8: On every non-active line (vertical sync, back porch, front porch), the whole active window is a fill interval of length `hact`.
- R9: `fill_mode` 1 issues one blanking packet (0x19), and 2 one null packet (0x09), on the first cycle of each fill interval, with word count 3 × interval length. `fill_mode` 0 or 3 issues no filler but raises `lp_ok` on every cycle of the interval. `lp_ok` is 0 outside fill intervals.
- R10: Every event carries `vchan` in `ev_vc`.
- R11: In burst mode, when the pixel packets fill the whole window (for example `max_pix` = 1), an active line has no filler and no `lp_ok` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches one frame when idle |
| hsw | input | 12 | Horizontal sync width, cycles |
| hbp | input | 12 | Horizontal back porch, cycles |
| hact | input | 12 | Active pixels per line |
| hfp | input | 12 | Horizontal front porch, cycles |
| vbp | input | 10 | Vertical back porch, lines |
| vact | input | 10 | Active lines |
| vfp | input | 10 | Vertical front porch, lines |
| max_pix | input | 12 | Largest pixel count per pixel packet |
| vid_mode | input | 2 | 0 sync pulses, 1 sync events, 2 burst, 3 as 1 |
| fill_mode | input | 2 | 0 low power, 1 blanking, 2 null, 3 as 0 |
| vchan | input | 2 | Virtual channel |
| ev_valid | output | 1 | An event is issued this cycle |
| ev_dt | output | 6 | Event data type |
| ev_vc | output | 2 | Event virtual channel |
| ev_wc | output | 16 | Event word count |
| lp_ok | output | 1 | Link may rest in low power this cycle |
| running | output | 1 | A frame is in progress |

## Verification
The frame-closing cycle and the acceptance of a fresh `start` fall on the same clock edge. The bench holds `start` high during the final cycle of a frame and also once in mid-frame. It then observes that the outputs stay idle for several cycles afterwards, with no new vertical-sync marker. In burst mode, the last pixel packet and the opening of the fill interval sit on adjacent cycles. The bench checks every cycle of several frames against a per-position model. That model derives chunk offsets by division and remainder instead of a running count.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int PW = 16;

  typedef enum logic [5:0] {
    DT_VSS    = 6'h01,
    DT_VSE    = 6'h11,
    DT_HSS    = 6'h21,
    DT_HSE    = 6'h31,
    DT_NULL   = 6'h09,
    DT_BLANK  = 6'h19,
    DT_RGB888 = 6'h3E
  } dtype_e;

  localparam logic [1:0] MODE_PULSE = 2'd0;
  localparam logic [1:0] MODE_BURST = 2'd2;
  localparam logic [1:0] FILL_BLANK = 2'd1;
  localparam logic [1:0] FILL_NULL  = 2'd2;

  // pixels carried by the next packet: capped by the programmed maximum
  function automatic logic [PW-1:0] chunk_pix(input logic [PW-1:0] cap,
                                               input logic [PW-1:0] left);
    return (left < cap) ? left : cap;
  endfunction

  // word count of a run of 24-bit pixels (three bytes each)
  function automatic logic [PW-1:0] wc_of(input logic [PW-1:0] pix);
    return PW'(pix * 3);
  endfunction
endpackage

// File: rtl/vseq_timebase.sv
module vseq_timebase import vseq_pkg::*; #(
  parameter int HW = 12,
  parameter int VW = 10,
  localparam int HCW = HW + 2,
  localparam int LNW = VW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [HW-1:0]  hsw,
  input  logic [HW-1:0]  hbp,
  input  logic [HW-1:0]  hact,
  input  logic [HW-1:0]  hfp,
  input  logic [VW-1:0]  vbp,
  input  logic [VW-1:0]  vact,
  input  logic [VW-1:0]  vfp,
  output logic [HCW-1:0] hc,
  output logic [LNW-1:0] line,
  output logic           running,
  output logic           frame_last
);
  logic [HCW-1:0] line_len;
  logic [LNW-1:0] n_lines;
  logic           last_hc, last_line;

  assign line_len   = HCW'(hsw) + HCW'(hbp) + HCW'(hact) + HCW'(hfp);
  assign n_lines    = LNW'(vbp) + LNW'(vact) + LNW'(vfp) + LNW'(1);
  assign last_hc    = (hc == line_len - HCW'(1));
  assign last_line  = (line == n_lines - LNW'(1));
  assign frame_last = running && last_hc && last_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      hc      <= '0;
      line    <= '0;
    end else if (!running) begin
      hc      <= '0;
      line    <= '0;
      if (start) running <= 1'b1;
    end else if (last_hc) begin
      hc <= '0;
      if (last_line) running <= 1'b0;
      else           line    <= line + LNW'(1);
    end else begin
      hc <= hc + HCW'(1);
    end
  end

  // R2: a frame only ends on its final cycle
  a_r2_frame_close: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(frame_last));
endmodule

// File: rtl/vseq_pixtrack.sv
module vseq_pixtrack import vseq_pkg::*; #(
  parameter int HW  = 12,
  parameter int WCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_win,
  input  logic           act_line,
  input  logic           burst,
  input  logic [HW-1:0]  o,
  input  logic [HW-1:0]  hact,
  input  logic [HW-1:0]  max_pix,
  output logic           chunk_fire,
  output logic [WCW-1:0] chunk_wc,
  output logic           bllp_win,
  output logic           bllp_first,
  output logic [WCW-1:0] bllp_wc
);
  logic [HW-1:0] sent, left, cpix;
  logic          tail_seen, tail_win, blank_win;

  assign left       = hact - sent;
  assign cpix       = HW'(chunk_pix(PW'(max_pix), PW'(left)));
  assign chunk_fire = in_win && act_line && (sent < hact) && (burst || (o == sent));
  assign chunk_wc   = WCW'(wc_of(PW'(cpix)));

  assign tail_win   = in_win && act_line && burst && (sent == hact);
  assign blank_win  = in_win && !act_line;
  assign bllp_win   = tail_win || blank_win;
  assign bllp_first = blank_win ? (o == '0) : (tail_win && !tail_seen);
  assign bllp_wc    = WCW'(wc_of(PW'(blank_win ? hact : (hact - o))));

  always_ff @(posedge clk) begin
    if (!rst_n || !in_win) begin
      sent      <= '0;
      tail_seen <= 1'b0;
    end else begin
      if (chunk_fire) sent      <= sent + cpix;
      if (tail_win)   tail_seen <= 1'b1;
    end
  end

  // R5: no pixel packet is empty or larger than the cap
  a_r5_chunk_cap: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_fire |-> (cpix != '0) && (cpix <= max_pix));
  // R6: issued pixels never pass the line length
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    sent <= hact);
  // R7: burst packets are back to back
  a_r7_burst_back2back: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_fire && burst && sent != '0) |-> $past(chunk_fire));
endmodule

// File: rtl/vseq_encode.sv
module vseq_encode import vseq_pkg::*; #(
  parameter int HW  = 12,
  parameter int VW  = 10,
  parameter int WCW = 16,
  localparam int HCW = HW + 2,
  localparam int LNW = VW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           running,
  input  logic [HCW-1:0] hc,
  input  logic [LNW-1:0] line,
  input  logic [HW-1:0]  hsw,
  input  logic [1:0]     vid_mode,
  input  logic [1:0]     fill_mode,
  input  logic [1:0]     vchan,
  input  logic           chunk_fire,
  input  logic [WCW-1:0] chunk_wc,
  input  logic           bllp_win,
  input  logic           bllp_first,
  input  logic [WCW-1:0] bllp_wc,
  output logic           ev_valid,
  output logic [5:0]     ev_dt,
  output logic [1:0]     ev_vc,
  output logic [WCW-1:0] ev_wc,
  output logic           lp_ok
);
  logic pulse, fill_pkt;

  assign pulse    = (vid_mode == MODE_PULSE);
  assign fill_pkt = (fill_mode == FILL_BLANK) || (fill_mode == FILL_NULL);
  assign ev_vc    = vchan;
  assign lp_ok    = running && bllp_win && !fill_pkt;

  always_comb begin
    ev_valid = 1'b0;
    ev_dt    = '0;
    ev_wc    = '0;
    if (running) begin
      if (hc == '0) begin
        ev_valid = 1'b1;
        if (line == '0)                  ev_dt = DT_VSS;
        else if (pulse && line == LNW'(1)) ev_dt = DT_VSE;
        else                             ev_dt = DT_HSS;
      end else if (pulse && hc == HCW'(hsw)) begin
        ev_valid = 1'b1;
        ev_dt    = DT_HSE;
      end else if (chunk_fire) begin
        ev_valid = 1'b1;
        ev_dt    = DT_RGB888;
        ev_wc    = chunk_wc;
      end else if (bllp_first && fill_pkt) begin
        ev_valid = 1'b1;
        ev_dt    = (fill_mode == FILL_BLANK) ? DT_BLANK : DT_NULL;
        ev_wc    = bllp_wc;
      end
    end
  end

  // R9: a low-power interval never overlaps an issued packet
  a_r9_lp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    lp_ok |-> !ev_valid);
endmodule

// File: rtl/dsi_vid_sequencer.sv
module dsi_vid_sequencer import vseq_pkg::*; #(
  parameter int HW  = 12,
  parameter int VW  = 10,
  parameter int WCW = 16,
  localparam int HCW = HW + 2,
  localparam int LNW = VW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [HW-1:0]  hsw,
  input  logic [HW-1:0]  hbp,
  input  logic [HW-1:0]  hact,
  input  logic [HW-1:0]  hfp,
  input  logic [VW-1:0]  vbp,
  input  logic [VW-1:0]  vact,
  input  logic [VW-1:0]  vfp,
  input  logic [HW-1:0]  max_pix,
  input  logic [1:0]     vid_mode,
  input  logic [1:0]     fill_mode,
  input  logic [1:0]     vchan,
  output logic           ev_valid,
  output logic [5:0]     ev_dt,
  output logic [1:0]     ev_vc,
  output logic [WCW-1:0] ev_wc,
  output logic           lp_ok,
  output logic           running
);
  logic [HCW-1:0] hc, win_base;
  logic [LNW-1:0] line, act_first;
  logic           frame_last, in_win, act_line;
  logic [HW-1:0]  o;
  logic           chunk_fire, bllp_win, bllp_first;
  logic [WCW-1:0] chunk_wc, bllp_wc;

  vseq_timebase #(.HW(HW), .VW(VW)) u_tb (
    .clk, .rst_n, .start, .hsw, .hbp, .hact, .hfp, .vbp, .vact, .vfp,
    .hc, .line, .running, .frame_last
  );

  assign win_base  = HCW'(hsw) + HCW'(hbp);
  assign in_win    = running && (hc >= win_base) && (hc < win_base + HCW'(hact));
  assign o         = HW'(hc - win_base);
  assign act_first = LNW'(vbp) + LNW'(1);
  assign act_line  = (line >= act_first) && (line < act_first + LNW'(vact));

  vseq_pixtrack #(.HW(HW), .WCW(WCW)) u_pt (
    .clk, .rst_n, .in_win, .act_line, .burst(vid_mode == MODE_BURST), .o,
    .hact, .max_pix, .chunk_fire, .chunk_wc, .bllp_win, .bllp_first, .bllp_wc
  );

  vseq_encode #(.HW(HW), .VW(VW), .WCW(WCW)) u_enc (
    .clk, .rst_n, .running, .hc, .line, .hsw, .vid_mode, .fill_mode, .vchan,
    .chunk_fire, .chunk_wc, .bllp_win, .bllp_first, .bllp_wc,
    .ev_valid, .ev_dt, .ev_vc, .ev_wc, .lp_ok
  );

  // R2: an accepted start opens the frame with vertical sync start
  a_r2_frame_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && start) |=> (ev_valid && ev_dt == DT_VSS));
endmodule

// File: tb/dsi_vid_sequencer_test.sv
module dsi_vid_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] hsw, hbp, hact, hfp, max_pix;
  logic [9:0]  vbp, vact, vfp;
  logic [1:0]  vid_mode, fill_mode, vchan;
  logic        ev_valid, lp_ok, running;
  logic [5:0]  ev_dt;
  logic [1:0]  ev_vc;
  logic [15:0] ev_wc;

  int checks = 0, fails = 0, act_fill_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dsi_vid_sequencer uut (
    .clk, .rst_n, .start, .hsw, .hbp, .hact, .hfp, .vbp, .vact, .vfp,
    .max_pix, .vid_mode, .fill_mode, .vchan,
    .ev_valid, .ev_dt, .ev_vc, .ev_wc, .lp_ok, .running
  );

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_at(int ln, int hc);
    int o, nch, dt, wc, flen;
    bit ev, lp, actl, inwin, infill, ffirst;
    string tag;
    ev = 0; lp = 0; dt = 0; wc = 0; infill = 0; ffirst = 0; flen = 0;
    o     = hc - (hsw + hbp);
    inwin = (o >= 0) && (o < hact);
    actl  = (ln >= 1 + vbp) && (ln < 1 + vbp + vact);
    nch   = (hact + max_pix - 1) / max_pix;
    tag   = "R3";
    if (hc == 0) begin
      ev = 1;
      dt = (ln == 0) ? 'h01 : ((ln == 1 && vid_mode == 0) ? 'h11 : 'h21);
    end else if (vid_mode == 0 && hc == hsw) begin
      ev = 1; dt = 'h31; tag = "R4";
    end else if (inwin && actl && vid_mode == 2) begin
      tag = "R7";
      if (o < nch) begin
        ev = 1; dt = 'h3E; wc = 3 * imin(max_pix, hact - o * max_pix);
        if (o == nch - 1) tag = "R6";
      end else begin
        infill = 1; ffirst = (o == nch); flen = hact - nch;
      end
    end else if (inwin && actl) begin
      tag = "R5";
      if (o % max_pix == 0) begin
        ev = 1; dt = 'h3E; wc = 3 * imin(max_pix, hact - o);
        if (o + max_pix >= hact) tag = "R6";
      end
    end else if (inwin) begin
      tag = "R8"; infill = 1; ffirst = (o == 0); flen = hact;
    end
    if (infill) begin
      if (fill_mode == 1 || fill_mode == 2) begin
        if (ffirst) begin
          ev = 1; dt = (fill_mode == 1) ? 'h19 : 'h09; wc = 3 * flen; tag = "R9";
        end
      end else begin
        lp = 1;
      end
    end
    if (actl && (lp_ok || (ev_valid && (ev_dt == 6'h19 || ev_dt == 6'h09))))
      act_fill_seen++;
    check(ev_valid === ev, tag, "valid", int'(ev_valid), int'(ev));
    if (ev) begin
      check(ev_dt === 6'(dt), tag, "data type", int'(ev_dt), dt);
      check(ev_wc === 16'(wc), tag, "word count", int'(ev_wc), wc);
      check(ev_vc === vchan, "R10", "channel", int'(ev_vc), int'(vchan));
    end
    check(lp_ok === lp, (lp || infill) ? "R9" : tag, "lp_ok", int'(lp_ok), int'(lp));
  endtask

  task automatic run_frame(bit poke);
    int L, nl, total;
    L = hsw + hbp + hact + hfp;
    nl = 1 + vbp + vact + vfp;
    total = L * nl;
    act_fill_seen = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int t = 0; t < total; t++) begin
      check(running === 1'b1, "R2", "running", int'(running), 1);
      expect_at(t / L, t % L);
      start = poke && (t == total / 2 || t == total - 1);
      @(negedge clk);
    end
    start = 0;
    for (int k = 0; k < 3; k++) begin
      check(running === 1'b0 && ev_valid === 1'b0 && lp_ok === 1'b0, "R2",
            "idle after frame", int'({running, ev_valid, lp_ok}), 0);
      @(negedge clk);
    end
  endtask

  task automatic setup(int sw, int bp, int act, int fp, int vb, int va, int vf,
                       int mp, int vm, int fm, int vc);
    hsw = 12'(sw); hbp = 12'(bp); hact = 12'(act); hfp = 12'(fp);
    vbp = 10'(vb); vact = 10'(va); vfp = 10'(vf); max_pix = 12'(mp);
    vid_mode = 2'(vm); fill_mode = 2'(fm); vchan = 2'(vc);
  endtask

  task automatic t_reset;
    rst_n = 0; start = 1;
    repeat (3) @(negedge clk);
    check(ev_valid === 1'b0 && lp_ok === 1'b0 && running === 1'b0, "R1",
          "outputs in reset", int'({ev_valid, lp_ok, running}), 0);
    start = 0; rst_n = 1;
    @(negedge clk);
    check(ev_valid === 1'b0 && lp_ok === 1'b0 && running === 1'b0, "R1",
          "outputs after reset", int'({ev_valid, lp_ok, running}), 0);
  endtask

  // R4 R6 R8 R9: sync pulses, remainder chunk, blanking filler
  task automatic t_pulse_blank;
    setup(2, 2, 10, 3, 1, 2, 1, 4, 0, 1, 1);
    run_frame(0);
  endtask

  // R2 R3 R5: sync events, exact chunks, null filler, starts ignored
  task automatic t_event_null_poke;
    setup(1, 3, 12, 0, 2, 2, 1, 4, 1, 2, 2);
    run_frame(1);
  endtask

  // R7 R9: burst with a tail interval in low power
  task automatic t_burst_lp;
    setup(3, 1, 10, 2, 1, 3, 2, 3, 2, 0, 3);
    run_frame(0);
  endtask

  // R11: burst fills the whole window, no tail filler
  task automatic t_burst_full;
    setup(2, 1, 5, 2, 0, 2, 1, 1, 2, 1, 0);
    run_frame(0);
    check(act_fill_seen == 0, "R11", "fill on active lines", act_fill_seen, 0);
  endtask

  // R5 R9: single oversized cap, low-power alias code 3
  task automatic t_pulse_single;
    setup(1, 1, 7, 1, 1, 1, 1, 20, 0, 3, 1);
    run_frame(0);
  endtask

  initial begin
    setup(1, 1, 1, 1, 0, 1, 0, 1, 0, 0, 0);
    t_reset();
    t_pulse_blank();
    t_event_null_poke();
    t_burst_lp();
    t_burst_full();
    t_pulse_single();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule